// File: doc/BRIEF.md
# Flash command status tracker

This block follows each command that a bus host sends to an embedded flash controller, from the moment the command is written until software acknowledges its result. It keeps one queued command waiting behind the one the flash is running. It offers the queued command to the flash arbiter, and it records whether each finished command succeeded or failed. All of this is shown in a read-only 32-bit status word that the APB read path returns.

Results are handed over through two write-1-to-clear interrupt bits, one for success and one for failure. If a command finishes while an earlier result is still unacknowledged, the new result is parked and a flag shows this. The parked result is loaded as soon as software clears the interrupt bits. A second host interface can lock the arbiter. While it does, no command is offered to the flash, and a status bit shows the lock.

Top module: `flash_cmd_status`

## Requirements
- R1: After reset the status word and both interrupt lines are 0, and status bits 31:6 always read 0. An APB read with the select high at byte address 0x018 returns the status word; any other address, or no select, returns 0.
- R2: Status bit 0 (pending) sets on a command write when nothing is queued. It clears in the cycle the arbiter accepts the offered command.
- R3: A command write that arrives while bit 0 is already set is dropped, and the drop error output sets and stays set until reset.
- R4: Status bit 1 (accepted) sets in the cycle pending clears through an accept. It stays set while the command runs, and it clears when the command finishes with its result loaded.
- R5: When a running command finishes and no interrupt bit is left set, exactly one of status bit 2 (success) and bit 3 (fail) is loaded from the flash fail flag. The matching interrupt line sets in the same cycle.
- R6: A clear strobe drops its interrupt line. Once both interrupt lines are low, status bits 2 and 3 read 0.
- R7: When a command finishes while an interrupt bit stays set, status bit 4 (deferred) sets, bits 2 and 3 keep their old values, and bit 1 stays set.
- R8: When the interrupt bits become clear while bit 4 is set, the parked result is loaded as in R5, and bits 4 and 1 clear.
- R9: The arbiter may take a queued command in the same cycle the running one finishes, provided no interrupt bit is left set. Bit 1 then stays high with no gap.
- R10: An abort written while a command runs and nothing is queued sets bit 0. Bit 0 clears when that command finishes. An abort at any other time is ignored.
- R11: Status bit 5 follows the lock input one cycle later. The request to the arbiter is low while the lock is high.
- R12: The request to the arbiter is high only when a command is queued and all of these hold: no abort is in progress, no lock, no parked result, and either no command is running or the running command finishes in that cycle with no interrupt bit left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Command written to the control register |
| abort_wr | input | 1 | Abort written to the control register |
| arb_accept | input | 1 | Arbiter takes the offered command |
| fl_done | input | 1 | Running command finished |
| fl_fail | input | 1 | Finished command failed (valid with fl_done) |
| host2_lock | input | 1 | Arbiter locked by the other host interface |
| clr_ok | input | 1 | Write-1-to-clear strobe, success interrupt |
| clr_err | input | 1 | Write-1-to-clear strobe, fail interrupt |
| apb_psel | input | 1 | APB select for a read |
| apb_paddr | input | ADDR_W | APB byte address |
| apb_prdata | output | DATA_W | APB read data |
| flash_req | output | 1 | Queued command offered to the arbiter |
| status | output | DATA_W | Status word |
| irq_ok | output | 1 | Success interrupt bit |
| irq_err | output | 1 | Fail interrupt bit |
| cmd_drop_err | output | 1 | Sticky flag for a dropped command write |

## Verification
The sharpest overlap is a command finishing in the same cycle as another event. That event can be the arbiter taking the next queued command, a clear strobe arriving, or an abort finishing. The bench first forces these collisions directly: a finish together with an accept, and a finish while an interrupt bit is still set, followed by a clear. It then runs several thousand cycles of random strobes from a fixed seed, in which finishes, accepts and clears often coincide. In every cycle, the status word, the interrupt lines, the request and the read data are compared against a bench model built from the requirements. That comparison decides whether bit 1 stayed high without a gap and whether a parked result was loaded exactly once.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    localparam int ST_PEND  = 0;
    localparam int ST_ACC   = 1;
    localparam int ST_OK    = 2;
    localparam int ST_FAIL  = 3;
    localparam int ST_DEFER = 4;
    localparam int ST_LOCK  = 5;
    localparam int ST_USED  = 6;

    typedef struct packed {
        logic pend;
        logic abort;
        logic inflight;
        logic drop;
    } q_state_t;

    typedef struct packed {
        logic ok;
        logic fail;
        logic defer;
        logic dfail;
        logic irq_ok;
        logic irq_err;
    } r_state_t;
endpackage

// File: rtl/fcs_queue.sv
module fcs_queue
    import fcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic abort_wr,
    input  logic arb_accept,
    input  logic done,
    input  logic lock,
    input  logic res_blocked,
    input  logic res_deferred,
    output logic pend,
    output logic inflight,
    output logic req,
    output logic drop_err
);
    q_state_t q_d, q_q;
    logic     fire;

    always_comb begin
        q_d  = q_q;
        req  = q_q.pend & ~q_q.abort & ~lock & ~res_deferred
             & (~q_q.inflight | (done & ~res_blocked));
        fire = req & arb_accept;

        if (fire)
            q_d.inflight = 1'b1;
        else if (done)
            q_d.inflight = 1'b0;

        if (q_q.abort && done) begin
            q_d.pend  = 1'b0;
            q_d.abort = 1'b0;
        end else if (fire) begin
            q_d.pend = 1'b0;
        end else if (cmd_wr && !q_q.pend) begin
            q_d.pend = 1'b1;
        end else if (abort_wr && !q_q.pend && q_q.inflight && !done) begin
            q_d.pend  = 1'b1;
            q_d.abort = 1'b1;
        end

        if (cmd_wr && q_q.pend)
            q_d.drop = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign pend     = q_q.pend;
    assign inflight = q_q.inflight;
    assign drop_err = q_q.drop;
endmodule

// File: rtl/fcs_result.sv
module fcs_result
    import fcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic fail_in,
    input  logic clr_ok,
    input  logic clr_err,
    output logic ok,
    output logic fail,
    output logic defer,
    output logic irq_ok,
    output logic irq_err,
    output logic blocked
);
    r_state_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        blocked = (r_q.irq_ok & ~clr_ok) | (r_q.irq_err & ~clr_err);
        r_d.irq_ok  = r_q.irq_ok  & ~clr_ok;
        r_d.irq_err = r_q.irq_err & ~clr_err;

        if (done && blocked) begin
            r_d.defer = 1'b1;
            r_d.dfail = fail_in;
        end else if (done || (r_q.defer && !blocked)) begin
            r_d.defer   = 1'b0;
            r_d.ok      = done ? ~fail_in : ~r_q.dfail;
            r_d.fail    = done ?  fail_in :  r_q.dfail;
            r_d.irq_ok  = r_d.ok;
            r_d.irq_err = r_d.fail;
        end else if (!r_d.irq_ok && !r_d.irq_err) begin
            r_d.ok   = 1'b0;
            r_d.fail = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ok      = r_q.ok;
    assign fail    = r_q.fail;
    assign defer   = r_q.defer;
    assign irq_ok  = r_q.irq_ok;
    assign irq_err = r_q.irq_err;
endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
    import fcs_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 12,
    parameter logic [11:0] STATUS_OFF = 12'h018
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              abort_wr,
    input  logic              arb_accept,
    input  logic              fl_done,
    input  logic              fl_fail,
    input  logic              host2_lock,
    input  logic              clr_ok,
    input  logic              clr_err,
    input  logic              apb_psel,
    input  logic [ADDR_W-1:0] apb_paddr,
    output logic [DATA_W-1:0] apb_prdata,
    output logic              flash_req,
    output logic [DATA_W-1:0] status,
    output logic              irq_ok,
    output logic              irq_err,
    output logic              cmd_drop_err
);
    localparam int PAD_W = DATA_W - ST_USED;
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(STATUS_OFF);

    logic lock_d, lock_q;
    logic pend, inflight, done_ok, blocked;
    logic r_ok, r_fail, r_defer;

    assign done_ok = fl_done & inflight;

    fcs_queue u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .abort_wr     (abort_wr),
        .arb_accept   (arb_accept),
        .done         (done_ok),
        .lock         (host2_lock),
        .res_blocked  (blocked),
        .res_deferred (r_defer),
        .pend         (pend),
        .inflight     (inflight),
        .req          (flash_req),
        .drop_err     (cmd_drop_err)
    );

    fcs_result u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (done_ok),
        .fail_in (fl_fail),
        .clr_ok  (clr_ok),
        .clr_err (clr_err),
        .ok      (r_ok),
        .fail    (r_fail),
        .defer   (r_defer),
        .irq_ok  (irq_ok),
        .irq_err (irq_err),
        .blocked (blocked)
    );

    always_comb lock_d = host2_lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_d;
    end

    always_comb begin
        status           = '0;
        status[ST_PEND]  = pend;
        status[ST_ACC]   = inflight | r_defer;
        status[ST_OK]    = r_ok;
        status[ST_FAIL]  = r_fail;
        status[ST_DEFER] = r_defer;
        status[ST_LOCK]  = lock_q;
        apb_prdata = (apb_psel && apb_paddr == OFF) ? status : '0;
    end

    logic [PAD_W-1:0] pad_unused;
    assign pad_unused = status[DATA_W-1:ST_USED];
endmodule

module fcs_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic              arb_accept,
    input logic              host2_lock,
    input logic              flash_req,
    input logic [DATA_W-1:0] status,
    input logic              irq_ok,
    input logic              irq_err,
    input logic              cmd_drop_err
);
    AST_PEND_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !status[0]) |=> status[0]); // R2
    AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_drop_err |=> cmd_drop_err); // R3
    AST_ACC_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_req && arb_accept) |=> (status[1] && !status[0])); // R4
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status[2], status[3]})); // R5
    AST_RESULT_MATCHES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] | status[3]) == (irq_ok | irq_err)); // R6
    AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && $past(status[4])) |-> $stable(status[3:2])); // R7
    AST_LOCK_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        host2_lock |-> !flash_req); // R11
    AST_DEFER_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        status[4] |-> !flash_req); // R12
endmodule

bind flash_cmd_status fcs_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (cmd_wr),
    .arb_accept   (arb_accept),
    .host2_lock   (host2_lock),
    .flash_req    (flash_req),
    .status       (status),
    .irq_ok       (irq_ok),
    .irq_err      (irq_err),
    .cmd_drop_err (cmd_drop_err)
);

// File: tb/sim_flash_cmd_status.sv
`timescale 1ns/1ps
module sim_flash_cmd_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 0, abort_wr = 0, arb_accept = 0, fl_done = 0, fl_fail = 0;
    logic        host2_lock = 0, clr_ok = 0, clr_err = 0, apb_psel = 0;
    logic [11:0] apb_paddr = '0;
    logic [31:0] apb_prdata, status;
    logic        flash_req, irq_ok, irq_err, cmd_drop_err;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    flash_cmd_status u0 (.*);

    // bench model of the requirements
    logic m_pend, m_abort, m_inf, m_drop, m_ok, m_fail, m_def, m_dfail, m_iok, m_ierr, m_lock;

    function automatic logic m_blocked();
        return (m_iok & ~clr_ok) | (m_ierr & ~clr_err);
    endfunction

    function automatic logic m_done();
        return fl_done & m_inf;
    endfunction

    function automatic logic m_req();
        return m_pend & ~m_abort & ~host2_lock & ~m_def & (~m_inf | (m_done() & ~m_blocked()));
    endfunction

    function automatic logic [31:0] m_status();
        logic [31:0] s = '0;
        s[0] = m_pend; s[1] = m_inf | m_def; s[2] = m_ok; s[3] = m_fail;
        s[4] = m_def;  s[5] = m_lock;
        return s;
    endfunction

    task automatic model_reset();
        {m_pend, m_abort, m_inf, m_drop, m_ok, m_fail, m_def, m_dfail, m_iok, m_ierr, m_lock} = '0;
    endtask

    task automatic model_step();
        logic dn = m_done();
        logic bl = m_blocked();
        logic fire = m_req() & arb_accept;
        logic n_pend = m_pend, n_abort = m_abort, n_inf = m_inf, n_drop = m_drop;
        logic n_ok = m_ok, n_fail = m_fail, n_def = m_def, n_dfail = m_dfail;
        logic n_iok = m_iok & ~clr_ok, n_ierr = m_ierr & ~clr_err;
        if (fire) n_inf = 1; else if (dn) n_inf = 0;
        if (m_abort && dn) begin n_pend = 0; n_abort = 0; end
        else if (fire) n_pend = 0;
        else if (cmd_wr && !m_pend) n_pend = 1;
        else if (abort_wr && !m_pend && m_inf && !dn) begin n_pend = 1; n_abort = 1; end
        if (cmd_wr && m_pend) n_drop = 1;
        if (dn && bl) begin n_def = 1; n_dfail = fl_fail; end
        else if (dn) begin
            n_def = 0; n_ok = ~fl_fail; n_fail = fl_fail; n_iok = ~fl_fail; n_ierr = fl_fail;
        end else if (m_def && !bl) begin
            n_def = 0; n_ok = ~m_dfail; n_fail = m_dfail; n_iok = ~m_dfail; n_ierr = m_dfail;
        end else if (!n_iok && !n_ierr) begin
            n_ok = 0; n_fail = 0;
        end
        m_pend = n_pend; m_abort = n_abort; m_inf = n_inf; m_drop = n_drop;
        m_ok = n_ok; m_fail = n_fail; m_def = n_def; m_dfail = n_dfail;
        m_iok = n_iok; m_ierr = n_ierr; m_lock = host2_lock;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_state();
        logic [31:0] s = m_status();
        chk("R2", "pending", 32'(status[0]), 32'(s[0]));
        chk("R4", "accepted", 32'(status[1]), 32'(s[1]));
        chk("R5", "success/fail", 32'(status[3:2]), 32'(s[3:2]));
        chk("R7", "deferred", 32'(status[4]), 32'(s[4]));
        chk("R11", "lock bit", 32'(status[5]), 32'(s[5]));
        chk("R1", "upper bits", 32'(status[31:6]), 32'd0);
        chk("R6", "interrupts", 32'({irq_ok, irq_err}), 32'({m_iok, m_ierr}));
        chk("R3", "drop error", 32'(cmd_drop_err), 32'(m_drop));
    endtask

    task automatic idle_inputs();
        {cmd_wr, abort_wr, arb_accept, fl_done, fl_fail, clr_ok, clr_err, apb_psel} = '0;
    endtask

    // inputs are set at the negedge; this checks the combinational paths, steps the model,
    // crosses one rising edge and compares the registered state at the next negedge
    task automatic cyc();
        #1;
        chk("R12", "request", 32'(flash_req), 32'(m_req()));
        chk("R1", "read data", apb_prdata, (apb_psel && apb_paddr == 12'h018) ? m_status() : 32'd0);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_state();
        idle_inputs();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_val;
        seed_val = $urandom(32'h5EED_0042);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and read path
        compare_state();
        chk("R1", "reset status", status, 32'd0);
        apb_psel = 1; apb_paddr = 12'h018; cyc();
        // R2: write then accept
        cmd_wr = 1; cyc();
        chk("R2", "pending after write", 32'(status[0]), 32'd1);
        arb_accept = 1; cyc();
        chk("R4", "accepted after take", 32'(status[1:0]), 32'b10);
        // R3: queue one, then overflow
        cmd_wr = 1; cyc();
        cmd_wr = 1; cyc();
        chk("R3", "drop flag", 32'(cmd_drop_err), 32'd1);
        // R9: finish and take next in one cycle
        fl_done = 1; arb_accept = 1; #1;
        chk("R9", "request at finish", 32'(flash_req), 32'd1);
        cyc();
        chk("R9", "accepted no gap", 32'(status[1:0]), 32'b10);
        chk("R5", "success loaded", 32'({status[3:2], irq_ok, irq_err}), 32'b0110);
        // R7: finish with failure while success interrupt still set
        fl_done = 1; fl_fail = 1; cyc();
        chk("R7", "parked", 32'(status[4:1]), 32'b1011);
        cmd_wr = 1; cyc();
        chk("R12", "no request while parked", 32'(flash_req), 32'd0);
        // R8: clear loads parked fail
        clr_ok = 1; cyc();
        chk("R8", "parked loaded", 32'({status[4:1], irq_ok, irq_err}), 32'b010001);
        arb_accept = 1; cyc();
        fl_done = 1; cyc();
        chk("R7", "parked success", 32'(status[4]), 32'd1);
        clr_err = 1; cyc();
        chk("R8", "success after clear", 32'(status[3:2]), 32'b01);
        // R6: clear empties result bits
        clr_ok = 1; cyc();
        chk("R6", "result cleared", 32'({status[4:1], irq_ok, irq_err}), 32'd0);
        // R10: abort of a running command
        cmd_wr = 1; cyc();
        arb_accept = 1; cyc();
        abort_wr = 1; cyc();
        chk("R10", "abort pending", 32'(status[1:0]), 32'b11);
        arb_accept = 1; cyc();
        fl_done = 1; cyc();
        chk("R10", "abort finished", 32'(status[1:0]), 32'b00);
        abort_wr = 1; cyc();
        chk("R10", "idle abort ignored", 32'(status[0]), 32'd0);
        clr_ok = 1; clr_err = 1; cyc();
        // R11: lock
        host2_lock = 1; cmd_wr = 1; cyc();
        chk("R11", "lock shown", 32'(status[5]), 32'd1);
        #1 chk("R11", "no request under lock", 32'(flash_req), 32'd0);
        host2_lock = 0; cyc();
        #1 chk("R11", "request after unlock", 32'(flash_req), 32'd1);
        apb_psel = 1; apb_paddr = 12'h01C; cyc();
        // random phase
        for (int i = 0; i < 5000; i++) begin
            cmd_wr     = ($urandom % 100) < 20;
            abort_wr   = ($urandom % 100) < 5;
            arb_accept = ($urandom % 100) < 60;
            fl_done    = ($urandom % 100) < 30;
            fl_fail    = $urandom % 2;
            host2_lock = ($urandom % 100) < 10;
            clr_ok     = ($urandom % 100) < 20;
            clr_err    = ($urandom % 100) < 20;
            apb_psel   = $urandom % 2;
            apb_paddr  = ($urandom % 2) ? 12'h018 : 12'($urandom);
            cyc();
        end
        host2_lock = 0;
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule